// File: doc/BRIEF.md
# Endpoint Transfer-Size Register Bank

This block sits on a 32-bit register bus next to a USB device controller's endpoint core. It stores the transfer size and the direction setting for every endpoint. Each write to a mapped location also sends a one-cycle size-load command to the core. The control endpoint has one short register, and its direction travels inside the written word. The fifteen transmit (IN) endpoints and the fifteen receive (OUT) endpoints each have their own window of word registers. For these endpoints the window that is written decides the direction of the command.

The bus side is a plain write strobe with an offset and write data. Read data comes back combinationally for the presented offset. The command side is handled by a two-state machine. `LD_IDLE` means no command is pending. `LD_ISSUE` is the single cycle in which the load strobe is high. `LD_IDLE` moves to `LD_ISSUE` on a write to any mapped location, and otherwise stays in `LD_IDLE`. `LD_ISSUE` stays in `LD_ISSUE` when another mapped write arrives, which gives back-to-back commands. Otherwise it returns to `LD_IDLE`. The endpoint number, size and direction are captured in the same cycle as the transition.

Top module: `ep_size_regfile`

## Requirements
- R1: After reset every mapped register reads 0 and `ld_valid` is low.
- R2: The control-endpoint register at offset 0x108 keeps only bits 8:0 of a write. A read of it returns those 9 bits, and bits 31:9 read as 0.
- R3: A write to offset 0x108 produces a command with `ld_ep` = 0, `ld_size` = write data bits 6:0 (zero-extended), and `ld_dir_tx` = write data bit 7.
- R4: Offsets 0x10C to 0x147 hold the 15 IN registers, and register k is at 0x10C + 4k. Each one stores and reads back all 32 bits (bit 31 is the enable flag, bits 30:0 the size).
- R5: A write to IN register k produces a command with `ld_ep` = k+1, `ld_size` = write data bits 30:0, and `ld_dir_tx` = 1.
- R6: Offsets 0x14C to 0x187 hold the 15 OUT registers, and register k is at 0x14C + 4k. A write stores all 32 bits and produces a command with `ld_ep` = k+1, `ld_size` = write data bits 30:0, and `ld_dir_tx` = 0. IN and OUT registers with the same k are independent.
- R7: `ld_valid` is high for exactly the one cycle that follows each mapped write. Writes on consecutive cycles give strobes on consecutive cycles, each carrying its own fields.
- R8: A write to any offset outside the three mapped ranges (0x148 to 0x14B included) changes no register and produces no strobe. A read of such an offset returns 0.
- R9: Address bits 1:0 are ignored. Any byte offset inside a register's word selects that register for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ld_valid | output | 1 | Size-load command strobe |
| ld_ep | output | 4 | Endpoint number of the command (0 to 15) |
| ld_size | output | 31 | Transfer size of the command |
| ld_dir_tx | output | 1 | Command direction: 1 = transmit, 0 = receive |

## Verification
Random writes are spread across the control, IN, OUT and unmapped offsets, with random low address bits and random data.
- Checking the command fields shows whether the endpoint number comes from the right window, and whether the direction comes from the window or from data bit 7.
- Reading back each written offset shows whether the storage masks correctly and whether IN and OUT entries with the same index stay independent.

Directed cases cover the following:
- The first and last entry of each window.
- The gap offsets just past each window.
- The reset contents.
- Two writes on consecutive cycles, which separates a true one-cycle registered strobe from a level that is held or merged.

// File: rtl/ep_regs_pkg.sv
package ep_regs_pkg;

    // Target selected by a bus offset
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_EP0  = 2'd1,
        TGT_IN   = 2'd2,
        TGT_OUT  = 2'd3
    } tgt_e;

    // Command generator states
    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_ISSUE = 1'b1
    } ld_state_e;

endpackage

// File: rtl/ep_addr_decode.sv
module ep_addr_decode
    import ep_regs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_EP   = 15,
    parameter int EP0_OFS  = 'h108,
    parameter int IN_BASE  = 'h10C,
    parameter int OUT_BASE = 'h14C,
    localparam int IDX_W   = $clog2(NUM_EP)
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] EP0_A   = ADDR_W'(EP0_OFS);
    localparam logic [ADDR_W-1:0] IN_LO   = ADDR_W'(IN_BASE);
    localparam logic [ADDR_W-1:0] IN_HI   = ADDR_W'(IN_BASE + 4 * NUM_EP);
    localparam logic [ADDR_W-1:0] OUT_LO  = ADDR_W'(OUT_BASE);
    localparam logic [ADDR_W-1:0] OUT_HI  = ADDR_W'(OUT_BASE + 4 * NUM_EP);

    logic [ADDR_W-3:0] word_a;
    logic [ADDR_W-3:0] in_word;
    logic [ADDR_W-3:0] out_word;
    logic              hit_ep0;
    logic              hit_in;
    logic              hit_out;

    // Word offset of the access; byte lanes are ignored
    assign word_a   = addr[ADDR_W-1:2];
    assign in_word  = word_a - IN_LO[ADDR_W-1:2];
    assign out_word = word_a - OUT_LO[ADDR_W-1:2];

    assign hit_ep0 = (word_a == EP0_A[ADDR_W-1:2]);
    assign hit_in  = (addr >= IN_LO)  && (addr < IN_HI);
    assign hit_out = (addr >= OUT_LO) && (addr < OUT_HI);

    always_comb begin
        tgt = TGT_NONE;
        idx = '0;
        if (hit_ep0) begin
            tgt = TGT_EP0;
        end else if (hit_in) begin
            tgt = TGT_IN;
            idx = in_word[IDX_W-1:0];
        end else if (hit_out) begin
            tgt = TGT_OUT;
            idx = out_word[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/ep_reg_store.sv
module ep_reg_store
    import ep_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_EP = 15,
    parameter int EP0_W  = 9,
    localparam int IDX_W = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [EP0_W-1:0]  ep0_q;
    logic [DATA_W-1:0] in_q  [NUM_EP];
    logic [DATA_W-1:0] out_q [NUM_EP];

    // Control endpoint: narrow register, upper write bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep0_q <= '0;
        end else if (wr_en && tgt == TGT_EP0) begin
            ep0_q <= wdata[EP0_W-1:0];
        end
    end

    // One full-width register per endpoint and direction
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_q[g] <= '0;
            end else if (wr_en && tgt == TGT_IN && idx == IDX_W'(g)) begin
                in_q[g] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q[g] <= '0;
            end else if (wr_en && tgt == TGT_OUT && idx == IDX_W'(g)) begin
                out_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        unique case (tgt)
            TGT_EP0: rdata = DATA_W'(ep0_q);
            TGT_IN:  rdata = in_q[idx];
            TGT_OUT: rdata = out_q[idx];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ep_load_fsm.sv
module ep_load_fsm
    import ep_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_EP = 15,
    parameter int EP0_SZ_W = 7,
    localparam int IDX_W  = $clog2(NUM_EP),
    localparam int EPN_W  = $clog2(NUM_EP + 1),
    localparam int SIZE_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              ld_valid,
    output logic [EPN_W-1:0]  ld_ep,
    output logic [SIZE_W-1:0] ld_size,
    output logic              ld_dir_tx
);

    ld_state_e state_q;
    ld_state_e state_d;
    logic      hit;

    assign hit = wr_en && (tgt != TGT_NONE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  state_d = hit ? LD_ISSUE : LD_IDLE;
            LD_ISSUE: state_d = hit ? LD_ISSUE : LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command fields captured with the transition into LD_ISSUE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_ep     <= '0;
            ld_size   <= '0;
            ld_dir_tx <= 1'b0;
        end else if (hit) begin
            unique case (tgt)
                TGT_EP0: begin
                    ld_ep     <= '0;
                    ld_size   <= SIZE_W'(wdata[EP0_SZ_W-1:0]);
                    ld_dir_tx <= wdata[EP0_SZ_W];
                end
                TGT_IN: begin
                    ld_ep     <= EPN_W'(idx) + EPN_W'(1);
                    ld_size   <= wdata[SIZE_W-1:0];
                    ld_dir_tx <= 1'b1;
                end
                TGT_OUT: begin
                    ld_ep     <= EPN_W'(idx) + EPN_W'(1);
                    ld_size   <= wdata[SIZE_W-1:0];
                    ld_dir_tx <= 1'b0;
                end
                default: begin
                    ld_ep     <= ld_ep;
                    ld_size   <= ld_size;
                    ld_dir_tx <= ld_dir_tx;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            LD_ISSUE: ld_valid = 1'b1;
            default:  ld_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/ep_size_regfile.sv
module ep_size_regfile
    import ep_regs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_EP   = 15,
    parameter int EP0_W    = 9,
    parameter int EP0_OFS  = 'h108,
    parameter int IN_BASE  = 'h10C,
    parameter int OUT_BASE = 'h14C,
    localparam int EPN_W   = $clog2(NUM_EP + 1),
    localparam int SIZE_W  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ld_valid,
    output logic [EPN_W-1:0]  ld_ep,
    output logic [SIZE_W-1:0] ld_size,
    output logic              ld_dir_tx
);

    localparam int IDX_W    = $clog2(NUM_EP);
    localparam int EP0_SZ_W = EP0_W - 2;

    tgt_e             tgt;
    logic [IDX_W-1:0] idx;

    ep_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_EP   (NUM_EP),
        .EP0_OFS  (EP0_OFS),
        .IN_BASE  (IN_BASE),
        .OUT_BASE (OUT_BASE)
    ) u_dec (
        .addr (bus_addr),
        .tgt  (tgt),
        .idx  (idx)
    );

    ep_reg_store #(
        .DATA_W (DATA_W),
        .NUM_EP (NUM_EP),
        .EP0_W  (EP0_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .tgt   (tgt),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (bus_rdata)
    );

    ep_load_fsm #(
        .DATA_W   (DATA_W),
        .NUM_EP   (NUM_EP),
        .EP0_SZ_W (EP0_SZ_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .tgt       (tgt),
        .idx       (idx),
        .wdata     (bus_wdata),
        .ld_valid  (ld_valid),
        .ld_ep     (ld_ep),
        .ld_size   (ld_size),
        .ld_dir_tx (ld_dir_tx)
    );

endmodule

// File: rtl/ep_size_regfile_chk.sv
module ep_size_regfile_chk #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_EP   = 15,
    parameter int EP0_W    = 9,
    parameter int EP0_OFS  = 'h108,
    parameter int OUT_BASE = 'h14C,
    localparam int EPN_W   = $clog2(NUM_EP + 1),
    localparam int SIZE_W  = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ld_valid,
    input logic [EPN_W-1:0]  ld_ep,
    input logic [SIZE_W-1:0] ld_size,
    input logic              ld_dir_tx
);

    localparam logic [ADDR_W-1:0] EP0_A  = ADDR_W'(EP0_OFS);
    localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(OUT_BASE + 4 * NUM_EP);

    // R7
    strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(bus_wr));

    // R7
    no_strobe_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !ld_valid);

    // R3
    ep0_size_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ep == '0) |-> (ld_size[SIZE_W-1:EP0_W-2] == '0));

    // R3
    ep0_dir_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ep == '0) |-> (ld_dir_tx == $past(bus_wdata[EP0_W-2])));

    // R2
    ep0_read_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:2] == EP0_A[ADDR_W-1:2]) |-> (bus_rdata[DATA_W-1:EP0_W] == '0));

    // R8
    above_map_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= TOP_A) |=> !ld_valid);

    // R8
    above_map_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= TOP_A) |-> (bus_rdata == '0));

endmodule

bind ep_size_regfile ep_size_regfile_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_EP   (NUM_EP),
    .EP0_W    (EP0_W),
    .EP0_OFS  (EP0_OFS),
    .OUT_BASE (OUT_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ld_valid  (ld_valid),
    .ld_ep     (ld_ep),
    .ld_size   (ld_size),
    .ld_dir_tx (ld_dir_tx)
);

// File: tb/ep_size_regfile_tb.sv
module ep_size_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ld_valid;
    logic [3:0]  ld_ep;
    logic [30:0] ld_size;
    logic        ld_dir_tx;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    // Reference contents
    logic [8:0]  m_ep0;
    logic [31:0] m_in  [15];
    logic [31:0] m_out [15];

    always #4 clk = ~clk;

    ep_size_regfile u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ld_valid  (ld_valid),
        .ld_ep     (ld_ep),
        .ld_size   (ld_size),
        .ld_dir_tx (ld_dir_tx)
    );

    // 0 none, 1 ep0, 2 in, 3 out
    function automatic int kind_of(logic [11:0] a);
        if (a[11:2] == 10'h042) return 1;
        if (a >= 12'h10C && a < 12'h148) return 2;
        if (a >= 12'h14C && a < 12'h188) return 3;
        return 0;
    endfunction

    function automatic int idx_of(logic [11:0] a);
        int k = kind_of(a);
        if (k == 2) return (int'(a) - 'h10C) >> 2;
        if (k == 3) return (int'(a) - 'h14C) >> 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        case (kind_of(a))
            1: return {23'd0, m_ep0};
            2: return m_in[idx_of(a)];
            3: return m_out[idx_of(a)];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        case (kind_of(a))
            1: m_ep0 = d[8:0];
            2: m_in[idx_of(a)] = d;
            3: m_out[idx_of(a)] = d;
            default: ;
        endcase
    endtask

    task automatic check_cmd(string req, logic [11:0] a, logic [31:0] d);
        int k = kind_of(a);
        if (k == 0) begin
            check(req, "no strobe", {63'd0, ld_valid}, 64'd0);
        end else begin
            check(req, "strobe", {63'd0, ld_valid}, 64'd1);
            check(req, "ep", {60'd0, ld_ep},
                  (k == 1) ? 64'd0 : 64'(idx_of(a) + 1));
            check(req, "size", {33'd0, ld_size},
                  (k == 1) ? {57'd0, d[6:0]} : {33'd0, d[30:0]});
            check(req, "dir", {63'd0, ld_dir_tx},
                  (k == 1) ? {63'd0, d[7]} : ((k == 2) ? 64'd1 : 64'd0));
        end
    endtask

    task automatic check_read(string req, logic [11:0] a);
        bus_addr = a;
        #1;
        check(req, "read", {32'd0, bus_rdata}, {32'd0, exp_read(a)});
    endtask

    // Write at one edge; command checked at the following negedge
    task automatic do_write(string req, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
        check_cmd(req, a, d);
        check_read(req, a);
    endtask

    function automatic logic [11:0] rand_addr(int sel);
        logic [1:0] lo = 2'($urandom);
        case (sel)
            0, 1, 2: return 12'h10C + 12'(4 * ($urandom % 15)) + 12'(lo);
            3, 4, 5: return 12'h14C + 12'(4 * ($urandom % 15)) + 12'(lo);
            6, 7:    return 12'h108 + 12'(lo);
            default: begin
                case ($urandom % 5)
                    0: return 12'h148 + 12'(lo);
                    1: return 12'h104 + 12'(lo);
                    2: return 12'h188 + 12'($urandom % 'h78);
                    3: return 12'($urandom % 'h100);
                    default: return 12'h200 + 12'($urandom % 'hE00);
                endcase
            end
        endcase
    endfunction

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2468));
        m_ep0 = '0;
        for (int i = 0; i < 15; i++) begin
            m_in[i] = '0;
            m_out[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents and idle strobe
        check("R1", "strobe after reset", {63'd0, ld_valid}, 64'd0);
        check_read("R1", 12'h108);
        check_read("R1", 12'h10C);
        check_read("R1", 12'h184);

        // R2 / R3 control endpoint masking and direction
        do_write("R2", 12'h108, 32'hFFFF_FFFF);
        do_write("R3", 12'h108, 32'h0000_0155);
        do_write("R3", 12'h10A, 32'hABCD_E07F);

        // R4 / R5 IN window edges
        do_write("R4", 12'h10C, 32'h8000_0001);
        do_write("R5", 12'h144, 32'h7FFF_FFFF);
        do_write("R9", 12'h113, 32'h1234_5678);
        check_read("R9", 12'h110);

        // R6 OUT window edges, independence from IN
        do_write("R6", 12'h14C, 32'hDEAD_BEEF);
        do_write("R6", 12'h184, 32'h0000_0042);
        check_read("R6", 12'h10C);
        check_read("R6", 12'h144);

        // R8 gaps and outside offsets
        do_write("R8", 12'h148, 32'hFFFF_FFFF);
        do_write("R8", 12'h188, 32'hFFFF_FFFF);
        do_write("R8", 12'h104, 32'hFFFF_FFFF);
        check_read("R8", 12'h144);
        check_read("R8", 12'h14C);

        // R7 back-to-back writes
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h110; bus_wdata = 32'h0000_0AAA;
        model_write(12'h110, 32'h0000_0AAA);
        @(negedge clk);
        check_cmd("R7", 12'h110, 32'h0000_0AAA);
        bus_addr = 12'h150; bus_wdata = 32'h0000_0555;
        model_write(12'h150, 32'h0000_0555);
        @(negedge clk);
        bus_wr = 1'b0;
        check_cmd("R7", 12'h150, 32'h0000_0555);
        @(negedge clk);
        check("R7", "strobe drops", {63'd0, ld_valid}, 64'd0);

        // Random mix across all targets
        for (int n = 0; n < 500; n++) begin
            logic [11:0] a = rand_addr(int'($urandom % 10));
            logic [31:0] d = $urandom;
            case (kind_of(a))
                1: do_write("R3", a, d);
                2: do_write("R5", a, d);
                3: do_write("R6", a, d);
                default: do_write("R8", a, d);
            endcase
        end

        // Full readback of the IN and OUT windows
        for (int i = 0; i < 15; i++) begin
            check_read("R4", 12'(12'h10C + 4 * i));
            check_read("R6", 12'(12'h14C + 4 * i));
        end
        check_read("R2", 12'h108);

        done = 1'b1;
        finish_run();
    end

endmodule